// File: doc/BRIEF.md
# Run-Length and Stuck-Output Health Detector

This block runs continuous health checks on a hardware entropy source. It watches two streams. The first is the serial stream of raw noise bits, each marked by a valid strobe. The second is the sequence of assembled output words, each marked by its own valid strobe. It reports three failures as single-cycle pulses to a status register.

The long-run pulse fires when a run of identical bits grows to the long-run threshold. This check follows the T4 run test of the common statistical test suites. The noise pulse fires when the same run grows further, to a second and higher threshold. The stuck pulse fires when an output word equals the word accepted before it.

Both run checks share one saturating run counter. The word check keeps a copy of the previous word. Deasserting enable clears all of this history.

Top module: `rng_health_run_stuck`

## Requirements
- R1: While reset is held and in the first cycle after it is released, all three failure outputs are low.
- R2: `long_run_fail_o` pulses high for one cycle. The pulse comes in the cycle after the accepted bit that brings the current run of identical bits to exactly LONG_RUN bits (default 34).
- R3: `noise_fail_o` pulses high for one cycle. The pulse comes in the cycle after the accepted bit that brings the current run to exactly NOISE_RUN bits (default 48, greater than LONG_RUN).
- R4: Within one run, each run-length failure pulses at most once, however long the run grows past its threshold.
- R5: An accepted bit that differs from the previous accepted bit restarts the run at length 1. A new run must then reach a threshold again before a new pulse.
- R6: `stuck_fail_o` pulses high for one cycle. The pulse comes in the cycle after an accepted word that equals the previously accepted word in all WORD_W bits.
- R7: The first word accepted after reset, or after enable rises, is never compared and never raises `stuck_fail_o`.
- R8: While `en_i` is low, bits and words are ignored and all failure outputs stay low. Lowering `en_i` discards the run length and the stored previous word.
- R9: A cycle with a valid strobe low neither extends nor breaks the bit run or the word history of that stream.
- R10: A sequence of identical consecutive words raises `stuck_fail_o` only once. It can pulse again only after a differing word has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; low clears all history |
| bit_valid_i | input | 1 | Raw bit strobe |
| bit_i | input | 1 | Raw noise bit |
| word_valid_i | input | 1 | Output word strobe |
| word_i | input | WORD_W | Assembled output word |
| long_run_fail_o | output | 1 | Long-run failure pulse |
| noise_fail_o | output | 1 | Noise (very long run) failure pulse |
| stuck_fail_o | output | 1 | Repeated-word failure pulse |

## Verification
The bench builds the block with WORD_W=4, LONG_RUN=4 and NOISE_RUN=6. Every run length from 1 up to past the noise threshold is then only a few cycles long. The bench drives runs of each length in both polarities, with valid gaps inserted, and adds enable drops in the middle of a run. With 4-bit words, all 256 ordered pairs of consecutive words are swept, each following an enable drop, so the first-word rule is checked every time. Repeated and alternating triples exercise the once-per-sequence rule for stuck words.

// File: rtl/rng_health_pkg.sv
package rng_health_pkg;
  typedef struct packed {
    logic long_run;
    logic noise;
    logic stuck;
  } health_flags_t;
endpackage

// File: rtl/run_len_tracker.sv
module run_len_tracker #(
  parameter int LONG_RUN  = 34,
  parameter int NOISE_RUN = 48,
  localparam int CntW     = $clog2(NOISE_RUN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bit_valid_i,
  input  logic bit_i,
  output logic long_o,
  output logic noise_o
);
  localparam logic [CntW-1:0] LongPre  = CntW'(LONG_RUN - 1);
  localparam logic [CntW-1:0] NoisePre = CntW'(NOISE_RUN - 1);
  localparam logic [CntW-1:0] CntMax   = CntW'(NOISE_RUN);

  logic [CntW-1:0] cnt_q, cnt_d;
  logic            prev_q, have_q;
  logic            accept, same;

  always_comb begin
    accept = en_i & bit_valid_i;
    same   = have_q & (bit_i == prev_q);
    if (!same)                cnt_d = CntW'(1);
    else if (cnt_q == CntMax) cnt_d = cnt_q;   // saturate
    else                      cnt_d = cnt_q + CntW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      prev_q  <= 1'b0;
      have_q  <= 1'b0;
      long_o  <= 1'b0;
      noise_o <= 1'b0;
    end else begin
      long_o  <= accept & same & (cnt_q == LongPre);
      noise_o <= accept & same & (cnt_q == NoisePre);
      if (!en_i) begin
        cnt_q  <= '0;
        prev_q <= 1'b0;
        have_q <= 1'b0;
      end else if (accept) begin
        cnt_q  <= cnt_d;
        prev_q <= bit_i;
        have_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/word_repeat_check.sv
module word_repeat_check #(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              stuck_o
);
  logic [WORD_W-1:0] prev_q;
  logic              have_q, rep_q;
  logic              accept, match;

  always_comb begin
    accept = en_i & word_valid_i;
    match  = accept & have_q & (word_i == prev_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      have_q  <= 1'b0;
      rep_q   <= 1'b0;
      stuck_o <= 1'b0;
    end else begin
      stuck_o <= match & ~rep_q;
      if (!en_i) begin
        prev_q <= '0;
        have_q <= 1'b0;
        rep_q  <= 1'b0;
      end else if (accept) begin
        prev_q <= word_i;
        have_q <= 1'b1;
        rep_q  <= match;  // hold off until a differing word
      end
    end
  end
endmodule

// File: rtl/rng_health_run_stuck.sv
module rng_health_run_stuck
  import rng_health_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int LONG_RUN  = 34,
  parameter int NOISE_RUN = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              bit_valid_i,
  input  logic              bit_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              long_run_fail_o,
  output logic              noise_fail_o,
  output logic              stuck_fail_o
);
  health_flags_t flags;

  run_len_tracker #(
    .LONG_RUN (LONG_RUN),
    .NOISE_RUN(NOISE_RUN)
  ) u_run (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .bit_valid_i(bit_valid_i),
    .bit_i      (bit_i),
    .long_o     (flags.long_run),
    .noise_o    (flags.noise)
  );

  word_repeat_check #(
    .WORD_W(WORD_W)
  ) u_word (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .word_valid_i(word_valid_i),
    .word_i      (word_i),
    .stuck_o     (flags.stuck)
  );

  assign long_run_fail_o = flags.long_run;
  assign noise_fail_o    = flags.noise;
  assign stuck_fail_o    = flags.stuck;
endmodule

// File: rtl/rng_health_checker.sv
module rng_health_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic bit_valid_i,
  input logic word_valid_i,
  input logic long_run_fail_o,
  input logic noise_fail_o,
  input logic stuck_fail_o
);
  AST_LONG_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_run_fail_o |=> !long_run_fail_o);  // R4
  AST_NOISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    noise_fail_o |=> !noise_fail_o);  // R4
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !(long_run_fail_o || noise_fail_o || stuck_fail_o));  // R8
  AST_NO_BIT_NO_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_i |=> !(long_run_fail_o || noise_fail_o));  // R9
  AST_NO_WORD_NO_STUCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_valid_i |=> !stuck_fail_o);  // R6
  AST_STUCK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuck_fail_o |=> !stuck_fail_o);  // R10
endmodule

bind rng_health_run_stuck rng_health_checker u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .en_i           (en_i),
  .bit_valid_i    (bit_valid_i),
  .word_valid_i   (word_valid_i),
  .long_run_fail_o(long_run_fail_o),
  .noise_fail_o   (noise_fail_o),
  .stuck_fail_o   (stuck_fail_o)
);

// File: tb/tb_rng_health_run_stuck.sv
module tb_rng_health_run_stuck;
  localparam int CLK_PERIOD = 10;
  localparam int WW = 4;
  localparam int LR = 4;
  localparam int NR = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, bv = 1'b0, b = 1'b0, wv = 1'b0;
  logic [WW-1:0] w = '0;
  logic lf, nf, sf;

  int n_tests = 0, n_fail = 0;

  // reference model state
  int m_run = 0; bit m_prev = 0, m_have = 0;
  logic [WW-1:0] m_pw = '0; bit m_whave = 0, m_rep = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rng_health_run_stuck #(.WORD_W(WW), .LONG_RUN(LR), .NOISE_RUN(NR)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .bit_valid_i(bv), .bit_i(b),
    .word_valid_i(wv), .word_i(w),
    .long_run_fail_o(lf), .noise_fail_o(nf), .stuck_fail_o(sf));

  task automatic chk(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag, input logic e, input logic v, input logic x,
                      input logic wvl, input logic [WW-1:0] wd);
    bit el = 0, en_ = 0, es = 0;
    int old;
    @(negedge clk);
    en = e; bv = v; b = x; wv = wvl; w = wd;
    if (!e) begin
      m_run = 0; m_have = 0; m_whave = 0; m_rep = 0;
    end else begin
      if (v) begin
        old = m_run;
        if (m_have && x == m_prev) m_run = (m_run < NR) ? m_run + 1 : NR;
        else m_run = 1;
        el = (m_run == LR) && (old != LR);
        en_ = (m_run == NR) && (old != NR);
        m_prev = x; m_have = 1;
      end
      if (wvl) begin
        bit m;
        m = m_whave && (wd == m_pw);
        es = m && !m_rep;
        m_rep = m; m_pw = wd; m_whave = 1;
      end
    end
    @(posedge clk); #(CLK_PERIOD/4);
    chk({tag, " R2 long"}, lf, el);
    chk({tag, " R3 noise"}, nf, en_);
    chk({tag, " R6 stuck"}, sf, es);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    n_fail++;
    $display("FAIL watchdog R1 act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2 + 1);
    chk("R1 reset long", lf, 1'b0);
    chk("R1 reset noise", nf, 1'b0);
    chk("R1 reset stuck", sf, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #(CLK_PERIOD/4);
    chk("R1 post-reset", lf | nf | sf, 1'b0);

    // R5 R4: runs of every length in both polarities, valid gaps inside (R9)
    for (int k = 1; k <= NR + 3; k++) begin
      for (int i = 0; i < k; i++) begin
        step("R5 run", 1, 1, k[0], 0, '0);
        if (i % 3 == 1) step("R9 gap", 1, 0, ~k[0], 0, '0);
      end
    end
    // R4: very long run saturates with single pulses
    for (int i = 0; i < 3*NR; i++) step("R4 sat", 1, 1, 1'b0, 0, '0);
    // R8: enable drop mid-run discards the count
    step("R8 brk", 1, 1, 1'b1, 0, '0);
    for (int i = 0; i < LR-1; i++) step("R8 pre", 1, 1, 1'b1, 0, '0);
    step("R8 off", 0, 1, 1'b1, 1, 4'h3);
    step("R8 off", 0, 1, 1'b1, 1, 4'h3);
    for (int i = 0; i < LR-1; i++) step("R8 post", 1, 1, 1'b1, 0, '0);
    step("R8 post", 1, 1, 1'b1, 0, '0);

    // R6 R7: all ordered word pairs, each after an enable drop
    for (int a = 0; a < (1 << WW); a++) begin
      for (int c = 0; c < (1 << WW); c++) begin
        step("R7 clr", 0, 0, 0, 0, '0);
        step("R7 first", 1, 0, 0, 1, WW'(a));
        step("R9 wgap", 1, 0, 0, 0, WW'(c + 1));
        step("R6 pair", 1, 0, 0, 1, WW'(c));
      end
    end
    // R10: repeated triples, alternating
    step("R10 clr", 0, 0, 0, 0, '0);
    for (int i = 0; i < 4; i++) step("R10 rep", 1, 0, 0, 1, 4'h5);
    step("R10 diff", 1, 0, 0, 1, 4'hA);
    step("R10 again", 1, 0, 0, 1, 4'hA);
    step("R10 again", 1, 0, 0, 1, 4'hA);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule